// File: doc/BRIEF.md
# Gamepad Song Selector

This block runs once for every vertical-sync pulse. On that pulse it raises a one-cycle interrupt request toward the processor, but only while the vector-override input says the player's own vectors are in effect. In the same frame it polls an eight-button serial gamepad. It latches the pad with a strobe pulse, then clocks the eight button bits out of the pad one at a time.

The sampled byte is compared with the byte from the previous frame, so that only buttons that have just gone down count as presses. A new Right press moves to the next song and a new Left press moves to the previous one. A new A press replays the current song. Any of these three raises a one-cycle restart request. A separate control block uses that request to schedule the song's initialisation again and to turn vector override back on.

The song number is 1-based and never wraps: it holds at 1 and at the configured song count. On reset it takes the configured starting song, limited to that range.

Top module: `pad_song_select`

## Requirements
- R1: A `vsync_pulse` sampled high while `vec_override` is high gives `nmi_req` high for exactly the following cycle. While `vec_override` is low, no `nmi_req` is produced.
- R2: Each `vsync_pulse` that arrives while no poll is running starts one poll. The poll holds `pad_latch` high for STROBE_CYC cycles, waits GAP_CYC cycles, then gives exactly 8 rising edges on `pad_clk`. A `vsync_pulse` that arrives during a poll starts no second poll.
- R3: A serial bit read as 1 means the button is pressed. The first bit read is button A, and the bits that follow are B, Select, Start, Up, Down, Left, Right. In the captured byte, A is bit 7 and Right is bit 0.
- R4: A button counts as fresh only when it is pressed in this poll and was not pressed in the previous poll. The previous-poll byte resets to all zeros, so a button held through reset produces exactly one fresh press.
- R5: A fresh Right without a fresh Left raises `song_num` by one, but not above `song_count`.
- R6: A fresh Left without a fresh Right lowers `song_num` by one, but not below 1. A fresh Left together with a fresh Right leaves `song_num` unchanged.
- R7: A fresh Right, Left or A gives one one-cycle pulse on `restart_req` for that poll. Fresh presses of B, Select, Start, Up or Down alone give no pulse and do not change `song_num`.
- R8: While `rst_n` is low, `song_num` loads `start_song`, clamped into the range 1 to `song_count`. A `start_song` of 0 gives 1.
- R9: `song_num` stays within 1 to `song_count` at all times, given a fixed `song_count` of 1 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsync_pulse | input | 1 | One-cycle frame event |
| vec_override | input | 1 | High while the player's vectors are in effect |
| start_song | input | SONG_W | Configured starting song, 1-based |
| song_count | input | SONG_W | Configured number of songs |
| pad_data | input | 1 | Serial button data from the pad, 1 = pressed |
| pad_latch | output | 1 | Pad strobe; high loads the pad's button state |
| pad_clk | output | 1 | Pad read clock; a rising edge advances to the next bit |
| nmi_req | output | 1 | One-cycle interrupt request |
| song_num | output | SONG_W | Current song, 1-based |
| restart_req | output | 1 | One-cycle request to reinitialise the current song |

## Verification
The hardest case to reach from the ports is a button that stays held across polls. It must give exactly one press on the first poll and nothing afterwards. The same holds for a button held through reset, where the zeroed previous-poll byte must still produce exactly one edge. The stimulus creates both cases: a model of the pad shift register holds a byte steady across several vsync events, and reset is applied while that byte is non-zero. A long sweep of computed button bytes mixes simultaneous presses and releases, including Left and Right together. Runs of Right-only and Left-only presses push the song number into both saturation limits.

// File: rtl/pss_pkg.sv
// Shared definitions for the gamepad song selector.
// Assumes the standard eight-button pad whose first serial bit is button A.
package pss_pkg;

    // Bit position of each button in the captured byte (first bit read = MSB).
    localparam int BTN_A      = 7;
    localparam int BTN_B      = 6;
    localparam int BTN_SELECT = 5;
    localparam int BTN_START  = 4;
    localparam int BTN_UP     = 3;
    localparam int BTN_DOWN   = 2;
    localparam int BTN_LEFT   = 1;
    localparam int BTN_RIGHT  = 0;

    // Phases of one pad poll.
    typedef enum logic [2:0] {
        PS_IDLE,
        PS_LATCH,
        PS_GAP,
        PS_SHIFT,
        PS_DONE
    } poll_state_t;

endpackage

// File: rtl/pss_poll_seq.sv
// Pad poll sequencer: on a start pulse it strobes the pad, waits, then
// clocks BTN_N bits out of it, MSB first. The captured byte is valid for
// one cycle, while the sequencer is in PS_DONE.
// Assumes STROBE_CYC >= 1, GAP_CYC >= 1, HALF_CYC >= 2, BTN_N >= 2.
// A start pulse that arrives while a poll is running is ignored.
module pss_poll_seq
    import pss_pkg::*;
#(
    parameter int BTN_N      = 8,
    parameter int STROBE_CYC = 2,
    parameter int GAP_CYC    = 2,
    parameter int HALF_CYC   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pad_data_i,
    output logic             pad_latch_o,
    output logic             pad_clk_o,
    output logic             frame_vld_o,
    output logic [BTN_N-1:0] frame_o
);

    localparam int T1   = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
    localparam int TMAX = (T1 > 2 * HALF_CYC) ? T1 : 2 * HALF_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(BTN_N);

    localparam logic [TW-1:0] STB_LAST  = TW'(STROBE_CYC - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CYC - 1);
    localparam logic [TW-1:0] SAMPLE_AT = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] CLK_HIGH  = TW'(HALF_CYC);
    localparam logic [TW-1:0] SLOT_LAST = TW'(2 * HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(BTN_N - 1);

    poll_state_t      state_q;
    logic [TW-1:0]    tick_q;
    logic [BW-1:0]    bit_q;
    logic [BTN_N-1:0] shift_q;

    // Outputs decoded from registered state only.
    assign pad_latch_o = (state_q == PS_LATCH);
    assign pad_clk_o   = (state_q == PS_SHIFT) && (tick_q >= CLK_HIGH);
    assign frame_vld_o = (state_q == PS_DONE);
    assign frame_o     = shift_q;

    // Walk through latch, gap and serial read phases, shifting bits in MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            tick_q  <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            case (state_q)
                PS_IDLE: begin
                    tick_q <= '0;
                    if (start_i) state_q <= PS_LATCH;
                end
                PS_LATCH: begin
                    if (tick_q == STB_LAST) begin
                        tick_q  <= '0;
                        state_q <= PS_GAP;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                PS_GAP: begin
                    if (tick_q == GAP_LAST) begin
                        tick_q  <= '0;
                        bit_q   <= '0;
                        state_q <= PS_SHIFT;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                PS_SHIFT: begin
                    if (tick_q == SAMPLE_AT)
                        shift_q <= {shift_q[BTN_N-2:0], pad_data_i};
                    if (tick_q == SLOT_LAST) begin
                        tick_q <= '0;
                        if (bit_q == BIT_LAST) state_q <= PS_DONE;
                        else                   bit_q   <= bit_q + 1'b1;
                    end else begin
                        tick_q <= tick_q + 1'b1;
                    end
                end
                PS_DONE:  state_q <= PS_IDLE;
                default:  state_q <= PS_IDLE;
            endcase
        end
    end

    // Checker state: length of the latch pulse and number of read-clock edges.
    logic [TW:0] latch_run_q;
    logic [BW:0] clk_rises_q;
    logic        pad_clk_q;

    // Count cycles of the strobe and rising edges of the read clock in each poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_run_q <= '0;
            clk_rises_q <= '0;
            pad_clk_q   <= 1'b0;
        end else begin
            pad_clk_q <= pad_clk_o;
            if (pad_latch_o)              latch_run_q <= latch_run_q + 1'b1;
            else if (state_q == PS_IDLE)  latch_run_q <= '0;
            if (pad_latch_o)                    clk_rises_q <= '0;
            else if (pad_clk_o && !pad_clk_q)   clk_rises_q <= clk_rises_q + 1'b1;
        end
    end

    a_r2_latch_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_latch_o) |-> (latch_run_q == (TW+1)'(STROBE_CYC)));

    a_r2_eight_clocks: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |-> (clk_rises_q == (BW+1)'(BTN_N)));

    a_r2_no_clock_in_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_latch_o) |-> (clk_rises_q != (BW+1)'(BTN_N)) || !pad_clk_o);

endmodule

// File: rtl/pss_edge_det.sv
// Rising-edge filter over the per-poll button byte: a bit is fresh when it is
// set in this poll and clear in the previous one. The previous byte resets to
// zero. The result is registered and valid for one cycle.
module pss_edge_det #(
    parameter int BTN_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld_i,
    input  logic [BTN_N-1:0] sample_i,
    output logic             fresh_vld_o,
    output logic [BTN_N-1:0] fresh_o
);

    logic [BTN_N-1:0] prev_q;

    // Keep the previous poll's byte and form the newly pressed bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            fresh_o     <= '0;
            fresh_vld_o <= 1'b0;
        end else begin
            fresh_vld_o <= sample_vld_i;
            if (sample_vld_i) begin
                fresh_o <= sample_i & ~prev_q;
                prev_q  <= sample_i;
            end
        end
    end

    // R4: every fresh bit is now recorded as held, so the next poll cannot repeat it.
    a_r4_fresh_now_held: assert property (@(posedge clk) disable iff (!rst_n)
        fresh_vld_o |-> ((fresh_o & ~prev_q) == '0));

endmodule

// File: rtl/pss_song_ctr.sv
// Saturating 1-based song counter driven by fresh button presses.
// Right steps up, Left steps down, and both together cancel. Right, Left or A
// raise a one-cycle restart request. Reset loads the clamped starting song.
// Assumes song_count stays fixed while out of reset; a count of 0 acts as 1.
module pss_song_ctr
    import pss_pkg::*;
#(
    parameter int BTN_N  = 8,
    parameter int SONG_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SONG_W-1:0] start_song_i,
    input  logic [SONG_W-1:0] song_count_i,
    input  logic              cmd_vld_i,
    input  logic [BTN_N-1:0]  fresh_i,
    output logic [SONG_W-1:0] song_o,
    output logic              restart_o
);

    localparam logic [SONG_W-1:0] ONE = {{(SONG_W-1){1'b0}}, 1'b1};

    logic [SONG_W-1:0] cap;
    logic              go_up;
    logic              go_dn;
    logic              do_restart;

    // Upper limit and decoded commands for this poll.
    always_comb begin
        cap        = (song_count_i == '0) ? ONE : song_count_i;
        go_up      = fresh_i[BTN_RIGHT] && !fresh_i[BTN_LEFT];
        go_dn      = fresh_i[BTN_LEFT]  && !fresh_i[BTN_RIGHT];
        do_restart = fresh_i[BTN_RIGHT] || fresh_i[BTN_LEFT] || fresh_i[BTN_A];
    end

    // Load the clamped start song in reset, then step with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_o <= 1'b0;
            if (start_song_i == '0)     song_o <= ONE;
            else if (start_song_i > cap) song_o <= cap;
            else                         song_o <= start_song_i;
        end else begin
            restart_o <= cmd_vld_i && do_restart;
            if (cmd_vld_i) begin
                if (go_up && song_o < cap)      song_o <= song_o + ONE;
                else if (go_dn && song_o > ONE) song_o <= song_o - ONE;
            end
        end
    end

    a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (song_o >= ONE) && (song_o <= cap));

    a_r7_change_with_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (song_o != $past(song_o)) |-> restart_o);

    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (song_o != $past(song_o)) |->
            ((song_o - $past(song_o)) == ONE) || (($past(song_o) - song_o) == ONE));

endmodule

// File: rtl/pad_song_select.sv
// Top of the gamepad song selector. On each vsync pulse it requests an NMI
// when vector override is active and starts one pad poll. The polled byte is
// edge-filtered, and the fresh presses drive the saturating song counter.
// Assumes vsync_pulse is a single-cycle pulse, synchronous to clk.
module pad_song_select
    import pss_pkg::*;
#(
    parameter int BTN_N      = 8,
    parameter int SONG_W     = 8,
    parameter int STROBE_CYC = 2,
    parameter int GAP_CYC    = 2,
    parameter int HALF_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_pulse,
    input  logic              vec_override,
    input  logic [SONG_W-1:0] start_song,
    input  logic [SONG_W-1:0] song_count,
    input  logic              pad_data,
    output logic              pad_latch,
    output logic              pad_clk,
    output logic              nmi_req,
    output logic [SONG_W-1:0] song_num,
    output logic              restart_req
);

    logic             frame_vld;
    logic [BTN_N-1:0] frame;
    logic             fresh_vld;
    logic [BTN_N-1:0] fresh;

    // Interrupt request for the frame, gated by vector override.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_req <= 1'b0;
        else        nmi_req <= vsync_pulse && vec_override;
    end

    pss_poll_seq #(
        .BTN_N     (BTN_N),
        .STROBE_CYC(STROBE_CYC),
        .GAP_CYC   (GAP_CYC),
        .HALF_CYC  (HALF_CYC)
    ) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (vsync_pulse),
        .pad_data_i (pad_data),
        .pad_latch_o(pad_latch),
        .pad_clk_o  (pad_clk),
        .frame_vld_o(frame_vld),
        .frame_o    (frame)
    );

    pss_edge_det #(
        .BTN_N(BTN_N)
    ) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_vld_i(frame_vld),
        .sample_i    (frame),
        .fresh_vld_o (fresh_vld),
        .fresh_o     (fresh)
    );

    pss_song_ctr #(
        .BTN_N (BTN_N),
        .SONG_W(SONG_W)
    ) u_song (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_song_i(start_song),
        .song_count_i(song_count),
        .cmd_vld_i   (fresh_vld),
        .fresh_i     (fresh),
        .song_o      (song_num),
        .restart_o   (restart_req)
    );

    a_r1_nmi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(vsync_pulse && vec_override));

    a_r1_nmi_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync_pulse && vec_override) |=> nmi_req);

    a_r7_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

endmodule

// File: tb/tb_pad_song_select.sv
// Self-checking bench: a pad shift-register model, a reference model of
// edge detection and song stepping, and per-poll checks at the ports.
module tb_pad_song_select;

    localparam int SONG_W = 8;
    localparam int STB    = 2;
    localparam int GAP    = 2;
    localparam int HALF   = 2;
    localparam int FRAME  = 1 + STB + GAP + 16 * HALF + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vsync_pulse = 1'b0;
    logic              vec_override = 1'b0;
    logic [SONG_W-1:0] start_song = 8'd3;
    logic [SONG_W-1:0] song_count = 8'd5;
    logic              pad_data;
    logic              pad_latch;
    logic              pad_clk;
    logic              nmi_req;
    logic [SONG_W-1:0] song_num;
    logic              restart_req;

    always #5 clk = ~clk;

    pad_song_select #(
        .SONG_W    (SONG_W),
        .STROBE_CYC(STB),
        .GAP_CYC   (GAP),
        .HALF_CYC  (HALF)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .vsync_pulse (vsync_pulse),
        .vec_override(vec_override),
        .start_song  (start_song),
        .song_count  (song_count),
        .pad_data    (pad_data),
        .pad_latch   (pad_latch),
        .pad_clk     (pad_clk),
        .nmi_req     (nmi_req),
        .song_num    (song_num),
        .restart_req (restart_req)
    );

    // Pad model: loads while strobed, shifts on each read-clock rise, 1 = pressed.
    logic [7:0] btn = 8'h00;
    logic [7:0] pad_sh = 8'h00;
    logic       pclk_q = 1'b0;
    assign pad_data = pad_sh[7];
    always @(posedge clk) begin
        pclk_q <= pad_clk;
        if (pad_latch)               pad_sh <= btn;
        else if (pad_clk && !pclk_q) pad_sh <= {pad_sh[6:0], 1'b1};
    end

    // Port event counters.
    int n_nmi = 0, n_rst = 0, n_latch = 0, n_clk = 0;
    logic latch_q = 1'b0;
    always @(posedge clk) begin
        latch_q <= pad_latch;
        if (rst_n && nmi_req)               n_nmi++;
        if (rst_n && restart_req)           n_rst++;
        if (rst_n && pad_latch && !latch_q) n_latch++;
        if (rst_n && pad_clk && !pclk_q)    n_clk++;
    end

    int tests = 0, fails = 0;
    int exp_song = 3;
    logic [7:0] prev_m = 8'h00;
    int cyc = 0;

    task automatic chk(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int s, input int c);
        @(negedge clk);
        rst_n = 1'b0;
        start_song = s[SONG_W-1:0];
        song_count = c[SONG_W-1:0];
        repeat (3) @(negedge clk);
        prev_m = 8'h00;
        exp_song = (s < 1) ? 1 : ((s > c) ? c : s);
        chk(int'(song_num), exp_song, "R8 reset load");
        chk(int'(nmi_req) + int'(restart_req) + int'(pad_latch), 0, "R8 reset outputs idle");
        rst_n = 1'b1;
    endtask

    // One poll with the given held buttons; model the expected result and check it.
    task automatic frame(input logic [7:0] b, input logic ovr, input string tag);
        logic [7:0] fr;
        int r0, n0, l0, c0, exp_r;
        btn = b;
        r0 = n_rst; n0 = n_nmi; l0 = n_latch; c0 = n_clk;
        @(negedge clk);
        vec_override = ovr;
        vsync_pulse = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
        chk(int'(nmi_req), int'(ovr), {tag, " R1 nmi"});
        repeat (FRAME) @(negedge clk);
        fr = b & ~prev_m;
        prev_m = b;
        if (fr[0] && !fr[1] && exp_song < int'(song_count)) exp_song++;
        if (fr[1] && !fr[0] && exp_song > 1) exp_song--;
        exp_r = (fr[0] || fr[1] || fr[7]) ? 1 : 0;
        chk(int'(song_num), exp_song, {tag, " R5/R6 song"});
        chk(n_rst - r0, exp_r, {tag, " R7/R4 restart"});
        chk(n_nmi - n0, int'(ovr), {tag, " R1 nmi count"});
        chk(n_latch - l0, 1, {tag, " R2 latch"});
        chk(n_clk - c0, 8, {tag, " R2 read clocks"});
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset(3, 5);
        // R3: single-button walk, A first (bit 7) down to Right (bit 0).
        for (int i = 7; i >= 0; i--) begin
            frame(8'h01 << i, 1'b1, "R3 walk");
            frame(8'h00, 1'b0, "R3 release");
        end
        // R4: a held Right steps once only.
        frame(8'h01, 1'b1, "R4 press");
        frame(8'h01, 1'b1, "R4 held");
        frame(8'h01, 1'b0, "R4 held");
        // R5: saturate at the count.
        for (int i = 0; i < 6; i++) begin
            frame(8'h00, 1'b0, "R5 gap");
            frame(8'h01, 1'b1, "R5 up");
        end
        chk(int'(song_num), 5, "R5 top limit");
        // R6: saturate at 1, then both together.
        for (int i = 0; i < 6; i++) begin
            frame(8'h00, 1'b0, "R6 gap");
            frame(8'h02, 1'b1, "R6 down");
        end
        chk(int'(song_num), 1, "R6 bottom limit");
        frame(8'h00, 1'b0, "R6 gap");
        frame(8'h03, 1'b1, "R6 both");
        // R7: non-navigation buttons only.
        frame(8'h00, 1'b0, "R7 gap");
        frame(8'h7C, 1'b1, "R7 others");
        // Sweep of computed patterns.
        for (int k = 0; k < 300; k++)
            frame(8'((k * 73 + (k >> 2)) & 255), k[0], "sweep");
        // R2: vsync during a poll starts no second poll.
        begin
            int l0;
            frame(8'h00, 1'b0, "R2 pre");
            l0 = n_latch;
            @(negedge clk); vsync_pulse = 1'b1;
            @(negedge clk); vsync_pulse = 1'b0;
            repeat (4) @(negedge clk);
            vsync_pulse = 1'b1;
            @(negedge clk); vsync_pulse = 1'b0;
            repeat (FRAME) @(negedge clk);
            chk(n_latch - l0, 1, "R2 overlap ignored");
        end
        // R8 clamp cases and R4 held-through-reset edge.
        do_reset(0, 5);
        do_reset(9, 5);
        btn = 8'h02;
        do_reset(4, 5);
        frame(8'h02, 1'b0, "R4 held at reset");
        frame(8'h02, 1'b0, "R4 still held");
        chk(int'(song_num), 3, "R9 range after reset hold");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule